// File: doc/BRIEF.md
# Periodic Firmware Integrity Scanner

The block checks that a region of program memory has not changed while the system runs. Software programs a word-address window, a 256-bit reference digest and a rescan interval. The block then reads the window through its own memory read port, so the processor is never stalled. It packs the words into blocks for an external hash core, which sits behind a valid/ready block interface. When the digest comes back, the block compares it with the reference. On a mismatch it raises a system reset request.

There are two modes. In on-demand mode, software starts a single hash and reads the digest back. The on-demand hash may first feed a secret 8-word seed into the hash stream, and it never compares or resets. In guard mode, set by a bit that software cannot clear, the block scans once at once. After each scan it waits the programmed interval and scans again. While guard mode is on, all configuration is frozen. The breach and range-error flags survive the soft reset that the block itself provokes, so boot code can find out why the system restarted.

Top module: `fw_scan_guard`

## Requirements
- R1: After a full reset, the status register (index 1) reads 0, `rst_req_o` is low and no memory request is issued.
- R2: An on-demand start (CTRL index 0, bit 0 written 1) reads every word from the start address (index 2) to the end address (index 3), end included. Each word is read exactly once, in ascending order. The digest then reads back at indices 24..31, and status bit 1 (done) becomes 1. A start equal to the end hashes one word.
- R3: With the seed bit (CTRL bit 2) set, the 8 seed words (indices 16..23, word 0 first) enter the hash stream before the memory words. Reads of the seed indices return 0.
- R4: If the end address is below the start address, a start sets status bit 3 (range error), issues no memory request and leaves the block idle.
- R5: Writing CTRL bit 1 with a 1 enables guard mode. Later writes of 0 to CTRL do not clear it; only a full or soft reset does. CTRL reads back bit 1 = guard and bit 2 = seed.
- R6: While guard mode is set, writes to the start, end, interval (index 4), reference (indices 8..15) and seed registers are ignored, and so is an on-demand start.
- R7: In guard mode, the first scan starts without waiting. Each later scan issues its first memory request no sooner than the interval (in cycles) after the previous digest arrived, and at most 6 cycles later than that.
- R8: In guard mode, a digest that differs from the reference raises `rst_req_o` for exactly 16 consecutive cycles. Status bit 2 (breach) is set in the same cycle the pulse starts. An on-demand hash never raises `rst_req_o`.
- R9: The soft reset (`soft_rst_i`) clears guard mode and the configuration but keeps status bits 2 and 3. A full reset clears them.
- R10: The memory port has at most one read outstanding: a request lasts one cycle, and the next request follows only after the read data has returned.
- R11: A block offered to the hash core stays valid and unchanged until it is accepted. Its word count is correct, and the first and last flags mark the first and final blocks of a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Full synchronous reset, active high |
| soft_rst_i | input | 1 | System soft reset; status flags survive it |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; data appears the next cycle |
| reg_idx_i | input | 5 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| mem_req_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| blk_valid_o | output | 1 | Hash block valid |
| blk_ready_i | input | 1 | Hash core accepts block |
| blk_data_o | output | 32*BLK_WORDS | Block words, word 0 in the low bits |
| blk_nwords_o | output | clog2(BLK_WORDS+1) | Number of valid words in block |
| blk_first_o | output | 1 | First block of a hash |
| blk_last_o | output | 1 | Final block of a hash |
| dig_valid_i | input | 1 | Digest valid from hash core |
| dig_i | input | 256 | Digest from hash core |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
Two events can meet in the same clock cycle. A digest mismatch that starts the reset pulse and sets the breach flag can coincide with the soft reset that this pulse then drives back into the block. The bench loops `rst_req_o` back into `soft_rst_i`. It corrupts one memory word between guard-mode scans. Every clock it checks that the pulse lasts 16 cycles, and it checks that the breach flag is still readable after the soft reset while guard mode has been cleared. A second overlap is a register write to a frozen field at the moment a guard scan is running. The bench does this write and then reads the field back.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int WORD_W    = 32;
  localparam int DIG_WORDS = 8;
  localparam int DIG_W     = WORD_W * DIG_WORDS;

  localparam logic [4:0] IDX_CTRL   = 5'd0;
  localparam logic [4:0] IDX_STATUS = 5'd1;
  localparam logic [4:0] IDX_START  = 5'd2;
  localparam logic [4:0] IDX_END    = 5'd3;
  localparam logic [4:0] IDX_PERIOD = 5'd4;
  localparam logic [1:0] GRP_REF    = 2'b01;
  localparam logic [1:0] GRP_SEED   = 2'b10;
  localparam logic [1:0] GRP_DIG    = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SEED, SQ_REQ, SQ_WAIT, SQ_SEND, SQ_DIG
  } sq_state_t;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
  import scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PER_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] cfg_start,
  output logic [ADDR_W-1:0] cfg_end,
  output logic [PER_W-1:0]  cfg_period,
  output logic [DIG_W-1:0]  cfg_ref,
  output logic [DIG_W-1:0]  cfg_seed,
  output logic              guard_en,
  output logic              seed_en,
  output logic              gp_go,
  output logic              breach_flag,
  input  logic              busy,
  input  logic              done_set,
  input  logic              err_set,
  input  logic              breach_set,
  input  logic              dig_set,
  input  logic [DIG_W-1:0]  dig_val
);
  logic [DIG_WORDS-1:0][WORD_W-1:0] ref_q, seed_q, dig_q;
  logic done_q, err_q;
  logic lock;

  assign lock        = guard_en;
  assign cfg_ref     = ref_q;
  assign cfg_seed    = seed_q;
  assign breach_flag = breach_q;

  logic breach_q;

  // Status flags that survive the soft reset
  always_ff @(posedge clk) begin
    if (rst) begin
      breach_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (breach_set) breach_q <= 1'b1;
      if (err_set)    err_q    <= 1'b1;
    end
  end

  // Configuration and volatile state
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg_start  <= '0;
      cfg_end    <= '0;
      cfg_period <= '0;
      ref_q      <= '0;
      seed_q     <= '0;
      dig_q      <= '0;
      guard_en   <= 1'b0;
      seed_en    <= 1'b0;
      gp_go      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      gp_go <= 1'b0;
      if (done_set) done_q <= 1'b1;
      if (dig_set)  dig_q  <= dig_val;
      if (reg_wr) begin
        unique case (reg_idx[4:3])
          2'b00: begin
            if (reg_idx == IDX_CTRL) begin
              if (reg_wdata[1]) guard_en <= 1'b1;
              if (!lock) seed_en <= reg_wdata[2];
              if (reg_wdata[0] && !lock && !busy) begin
                gp_go  <= 1'b1;
                done_q <= 1'b0;
              end
            end else if (reg_idx == IDX_START && !lock) begin
              cfg_start <= reg_wdata[ADDR_W-1:0];
            end else if (reg_idx == IDX_END && !lock) begin
              cfg_end <= reg_wdata[ADDR_W-1:0];
            end else if (reg_idx == IDX_PERIOD && !lock) begin
              cfg_period <= reg_wdata[PER_W-1:0];
            end
          end
          GRP_REF:  if (!lock) ref_q[reg_idx[2:0]]  <= reg_wdata;
          GRP_SEED: if (!lock) seed_q[reg_idx[2:0]] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // Registered read port; seed words are write-only
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_idx[4:3])
        2'b00: begin
          case (reg_idx)
            IDX_CTRL:   reg_rdata <= {29'd0, seed_en, guard_en, 1'b0};
            IDX_STATUS: reg_rdata <= {28'd0, err_q, breach_q, done_q, busy};
            IDX_START:  reg_rdata <= 32'(cfg_start);
            IDX_END:    reg_rdata <= 32'(cfg_end);
            IDX_PERIOD: reg_rdata <= 32'(cfg_period);
            default:    reg_rdata <= '0;
          endcase
        end
        GRP_REF:  reg_rdata <= ref_q[reg_idx[2:0]];
        GRP_SEED: reg_rdata <= '0;
        default:  reg_rdata <= dig_q[reg_idx[2:0]];
      endcase
    end
  end

  AST_GUARD_STICKY: assert property (@(posedge clk) disable iff (rst || soft_rst)
    guard_en |=> guard_en); // R5
  AST_START_LOCKED: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (guard_en && reg_wr && reg_idx == IDX_START) |=> $stable(cfg_start)); // R6
  AST_NO_GO_IN_GUARD: assert property (@(posedge clk) disable iff (rst || soft_rst)
    guard_en |=> !gp_go); // R6
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_WORDS = 16,
  localparam int CW  = $clog2(BLK_WORDS + 1),
  localparam int IW  = $clog2(BLK_WORDS),
  localparam int SVW = $clog2(DIG_WORDS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      guard_mode,
  input  logic                      seed_en,
  input  logic [ADDR_W-1:0]         cfg_start,
  input  logic [ADDR_W-1:0]         cfg_end,
  input  logic [DIG_W-1:0]          cfg_ref,
  input  logic [DIG_W-1:0]          cfg_seed,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_rvalid,
  input  logic [31:0]               mem_rdata,
  output logic                      blk_valid,
  input  logic                      blk_ready,
  output logic [32*BLK_WORDS-1:0]   blk_data,
  output logic [CW-1:0]             blk_nwords,
  output logic                      blk_first,
  output logic                      blk_last,
  input  logic                      dig_valid,
  input  logic [DIG_W-1:0]          dig,
  output logic                      busy,
  output logic                      done_pulse,
  output logic                      err_pulse,
  output logic                      fire,
  output logic                      dig_cap
);
  sq_state_t         st;
  logic [ADDR_W-1:0] addr, endr;
  logic [CW-1:0]     cnt;
  logic [SVW-1:0]    svi;
  logic              first_f, last_f, fm, seed_f;
  logic              bad_range;
  logic              wr_en;
  logic [31:0]       wr_data;
  logic [31:0]       bufw [BLK_WORDS];

  assign bad_range  = cfg_end < cfg_start;
  assign busy       = st != SQ_IDLE;
  assign err_pulse  = (st == SQ_IDLE) && start && bad_range;
  assign dig_cap    = (st == SQ_DIG) && dig_valid;
  assign done_pulse = dig_cap || err_pulse;
  assign fire       = dig_cap && fm && (dig != cfg_ref);

  assign blk_valid  = st == SQ_SEND;
  assign blk_nwords = cnt;
  assign blk_first  = first_f;
  assign blk_last   = last_f;

  assign wr_en   = (st == SQ_SEED) || ((st == SQ_WAIT) && mem_rvalid);
  assign wr_data = (st == SQ_SEED) ? cfg_seed[32*svi +: 32] : mem_rdata;

  // Block assembly buffer, no reset so it maps to plain storage
  always_ff @(posedge clk) begin
    if (wr_en) bufw[cnt[IW-1:0]] <= wr_data;
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk
    assign blk_data[32*g +: 32] = bufw[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      addr     <= '0;
      endr     <= '0;
      cnt      <= '0;
      svi      <= '0;
      first_f  <= 1'b0;
      last_f   <= 1'b0;
      fm       <= 1'b0;
      seed_f   <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      unique case (st)
        SQ_IDLE: if (start && !bad_range) begin
          addr    <= cfg_start;
          endr    <= cfg_end;
          cnt     <= '0;
          svi     <= '0;
          first_f <= 1'b1;
          last_f  <= 1'b0;
          fm      <= guard_mode;
          seed_f  <= seed_en && !guard_mode;
          st      <= (seed_en && !guard_mode) ? SQ_SEED : SQ_REQ;
        end
        SQ_SEED: begin
          cnt <= cnt + 1'b1;
          svi <= svi + 1'b1;
          if (cnt == CW'(BLK_WORDS - 1))        st <= SQ_SEND;
          else if (svi == SVW'(DIG_WORDS - 1))  st <= SQ_REQ;
        end
        SQ_REQ: begin
          mem_req  <= 1'b1;
          mem_addr <= addr;
          st       <= SQ_WAIT;
        end
        SQ_WAIT: if (mem_rvalid) begin
          cnt <= cnt + 1'b1;
          if (addr == endr) begin
            last_f <= 1'b1;
            st     <= SQ_SEND;
          end else begin
            addr <= addr + 1'b1;
            st   <= (cnt == CW'(BLK_WORDS - 1)) ? SQ_SEND : SQ_REQ;
          end
        end
        SQ_SEND: if (blk_ready) begin
          first_f <= 1'b0;
          cnt     <= '0;
          if (last_f)                                   st <= SQ_DIG;
          else if (seed_f && svi != SVW'(DIG_WORDS))    st <= SQ_SEED;
          else                                          st <= SQ_REQ;
        end
        SQ_DIG: if (dig_valid) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R10
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr <= endr)); // R2
  AST_BAD_RANGE_IDLE: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !busy && !mem_req); // R4
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_ready) |=> blk_valid && $stable(blk_data) && $stable(blk_nwords)); // R11
  AST_NO_GP_FIRE: assert property (@(posedge clk) disable iff (rst)
    (dig_cap && !fm) |-> !fire); // R8
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;
  logic             run;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= period;
      run <= 1'b1;
    end else if (tick) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R7
endmodule

// File: rtl/rst_pulse.sv
module rst_pulse #(
  parameter int RST_CYC = 16,
  localparam int RW = $clog2(RST_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic req
);
  logic [RW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      req  <= 1'b0;
    end else if (fire && !req) begin
      left <= RW'(RST_CYC - 1);
      req  <= 1'b1;
    end else if (req) begin
      if (left == '0) req <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  AST_PULSE_MIN2: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |=> req); // R8
endmodule

// File: rtl/fw_scan_guard.sv
module fw_scan_guard
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PER_W     = 24,
  parameter int BLK_WORDS = 16,
  parameter int RST_CYC   = 16,
  localparam int CW = $clog2(BLK_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    soft_rst_i,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [4:0]              reg_idx_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [31:0]             mem_rdata_i,
  output logic                    blk_valid_o,
  input  logic                    blk_ready_i,
  output logic [32*BLK_WORDS-1:0] blk_data_o,
  output logic [CW-1:0]           blk_nwords_o,
  output logic                    blk_first_o,
  output logic                    blk_last_o,
  input  logic                    dig_valid_i,
  input  logic [DIG_W-1:0]        dig_i,
  output logic                    rst_req_o
);
  logic              vrst;
  logic [ADDR_W-1:0] cfg_start, cfg_end;
  logic [PER_W-1:0]  cfg_period;
  logic [DIG_W-1:0]  cfg_ref, cfg_seed;
  logic              guard_en, seed_en, gp_go, breach_flag;
  logic              busy, done_pulse, err_pulse, fire, dig_cap;
  logic              tick, guard_q, due, g_start, start;

  assign vrst    = rst || soft_rst_i;
  assign g_start = guard_en && due && !busy;
  assign start   = g_start || gp_go;

  // Scan request bookkeeping for guard mode
  always_ff @(posedge clk) begin
    if (vrst) begin
      guard_q <= 1'b0;
      due     <= 1'b0;
    end else begin
      guard_q <= guard_en;
      if (g_start)                            due <= 1'b0;
      else if ((guard_en && !guard_q) || tick) due <= 1'b1;
    end
  end

  scan_regs #(.ADDR_W(ADDR_W), .PER_W(PER_W)) i_regs (
    .clk, .rst, .soft_rst(soft_rst_i),
    .reg_wr(reg_wr_i), .reg_rd(reg_rd_i), .reg_idx(reg_idx_i),
    .reg_wdata(reg_wdata_i), .reg_rdata(reg_rdata_o),
    .cfg_start, .cfg_end, .cfg_period, .cfg_ref, .cfg_seed,
    .guard_en, .seed_en, .gp_go, .breach_flag, .busy,
    .done_set(done_pulse), .err_set(err_pulse), .breach_set(fire),
    .dig_set(dig_cap), .dig_val(dig_i)
  );

  scan_seq #(.ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS)) i_seq (
    .clk, .rst(vrst), .start, .guard_mode(guard_en), .seed_en,
    .cfg_start, .cfg_end, .cfg_ref, .cfg_seed,
    .mem_req(mem_req_o), .mem_addr(mem_addr_o),
    .mem_rvalid(mem_rvalid_i), .mem_rdata(mem_rdata_i),
    .blk_valid(blk_valid_o), .blk_ready(blk_ready_i), .blk_data(blk_data_o),
    .blk_nwords(blk_nwords_o), .blk_first(blk_first_o), .blk_last(blk_last_o),
    .dig_valid(dig_valid_i), .dig(dig_i),
    .busy, .done_pulse, .err_pulse, .fire, .dig_cap
  );

  scan_timer #(.PER_W(PER_W)) i_timer (
    .clk, .rst(vrst), .load(done_pulse && guard_en),
    .period(cfg_period), .tick
  );

  rst_pulse #(.RST_CYC(RST_CYC)) i_pulse (
    .clk, .rst, .fire, .req(rst_req_o)
  );

  AST_BREACH_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> breach_flag); // R8
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (vrst)
    busy |-> !gp_go); // R6
endmodule

// File: tb/test_fw_scan_guard.sv
module test_fw_scan_guard;
  localparam int AW = 16;
  localparam int BW = 16;
  localparam int CWB = $clog2(BW + 1);
  localparam logic [31:0] SEED0 = 32'h1234_5678;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata;
  logic blk_valid, blk_ready, blk_first, blk_last;
  logic [32*BW-1:0] blk_data;
  logic [CWB-1:0] blk_nwords;
  logic dig_valid;
  logic [255:0] dig;
  logic rst_req;

  always #5 clk = ~clk;

  fw_scan_guard i_fw_scan_guard (
    .clk, .rst, .soft_rst_i(rst_req),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .blk_valid_o(blk_valid), .blk_ready_i(blk_ready), .blk_data_o(blk_data),
    .blk_nwords_o(blk_nwords), .blk_first_o(blk_first), .blk_last_o(blk_last),
    .dig_valid_i(dig_valid), .dig_i(dig), .rst_req_o(rst_req)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [256];
  logic [31:0] seedw [8];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: two-cycle read latency
  logic p1_v = 0, p2_v = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    p1_v <= mem_req; p1_a <= mem_addr;
    p2_v <= p1_v;    p2_a <= p1_a;
  end
  assign mem_rvalid = p2_v;
  assign mem_rdata  = mem[p2_a[7:0]];

  // Hash core stand-in with stalls
  logic [31:0] acc = '0;
  int dcnt = 0, nblk = 0;
  int bn [4];
  bit bf [4], bl [4];
  assign blk_ready = (cyc % 3) != 2;
  always @(posedge clk) begin
    dig_valid <= 1'b0;
    if (dcnt != 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) dig_valid <= 1'b1;
    end
    if (blk_valid && blk_ready) begin
      logic [31:0] a;
      a = blk_first ? SEED0 : acc;
      for (int i = 0; i < BW; i++)
        if (i < int'(blk_nwords)) a = a * 33 ^ blk_data[32*i +: 32];
      acc <= a;
      if (nblk < 4) begin bn[nblk] = int'(blk_nwords); bf[nblk] = blk_first; bl[nblk] = blk_last; end
      nblk <= nblk + 1;
      if (blk_last) dcnt <= 3;
    end
  end
  for (genvar k = 0; k < 8; k++) begin : g_dig
    assign dig[32*k +: 32] = acc + 32'(k);
  end

  function automatic logic [255:0] model_dig(input int s, input int e, input bit sd);
    logic [31:0] a;
    logic [255:0] r;
    a = SEED0;
    if (sd) for (int i = 0; i < 8; i++) a = a * 33 ^ seedw[i];
    for (int i = s; i <= e; i++) a = a * 33 ^ mem[i];
    for (int k = 0; k < 8; k++) r[32*k +: 32] = a + 32'(k);
    return r;
  endfunction

  // Per-clock reference comparison
  int exp_addr = 0, nreq = 0, hi_run = 0, last_dig = -1, gap_lo = -1, gap_hi = 0, gap_seen = 0;
  int win_lo = 0;
  bit allow_rst = 0, outstanding = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) begin
        chk(int'(mem_addr) == exp_addr, "R2 address order", mem_addr, exp_addr);
        chk(!outstanding, "R10 one outstanding", 1, 0);
        if (gap_lo >= 0 && last_dig >= 0 && int'(mem_addr) == win_lo) begin
          chk((cyc - last_dig) >= gap_lo && (cyc - last_dig) <= gap_lo + 6, "R7 interval",
              cyc - last_dig, gap_lo);
          gap_seen++;
        end
        outstanding = 1;
        exp_addr++;
        nreq++;
      end
      if (mem_rvalid) outstanding = 0;
      if (dig_valid) last_dig = cyc;
      if (rst_req) begin
        hi_run++;
        if (!allow_rst) chk(0, "R8 unexpected reset request", 1, 0);
      end else if (hi_run != 0) begin
        chk(hi_run == 16, "R8 pulse length", hi_run, 16);
        hi_run = 0;
      end
    end
  end

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [4:0] idx, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_idx = idx;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask
  task automatic wait_done();
    logic [31:0] s;
    do rd(5'd1, s); while (s[0] || !s[1]);
  endtask
  task automatic check_dig(input logic [255:0] e, input string req);
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(5'(24 + k), d);
      chk(d == e[32*k +: 32], req, d, e[32*k +: 32]);
    end
  endtask
  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    logic [31:0] d;
    logic [255:0] e;
    int n0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h9E37_79B9 * 32'(i + 1) ^ 32'(i << 7);
    for (int i = 0; i < 8; i++) seedw[i] = 32'hA5A5_0000 + 32'(i * 17);
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(5'd1, d);
    chk(d == 0, "R1 status after reset", d, 0);
    chk(rst_req == 0 && nreq == 0, "R1 idle outputs", nreq, 0);

    // R2 and R11: two-block on-demand hash, reference deliberately wrong
    for (int k = 0; k < 8; k++) wr(5'(8 + k), 32'hDEAD_0000);
    wr(5'd2, 4); wr(5'd3, 20);
    exp_addr = 4; nblk = 0;
    wr(5'd0, 1);
    wait_done();
    check_dig(model_dig(4, 20, 0), "R2 digest two blocks");
    chk(nreq == 17, "R2 word count", nreq, 17);
    chk(bn[0] == 16 && bf[0] && !bl[0], "R11 first block", bn[0], 16);
    chk(bn[1] == 1 && !bf[1] && bl[1], "R11 last block", bn[1], 1);
    chk(nblk == 2, "R11 block count", nblk, 2);

    // R2 boundary: single word
    wr(5'd2, 50); wr(5'd3, 50);
    exp_addr = 50; n0 = nreq;
    wr(5'd0, 1);
    wait_done();
    check_dig(model_dig(50, 50, 0), "R2 single word");
    chk(nreq - n0 == 1, "R2 single read", nreq - n0, 1);

    // R3 seed prefix
    for (int k = 0; k < 8; k++) wr(5'(16 + k), seedw[k]);
    rd(5'd17, d);
    chk(d == 0, "R3 seed unreadable", d, 0);
    wr(5'd2, 0); wr(5'd3, 3);
    exp_addr = 0; nblk = 0;
    wr(5'd0, 32'h5);
    wait_done();
    check_dig(model_dig(0, 3, 1), "R3 seeded digest");
    chk(bn[0] == 12 && bf[0] && bl[0], "R3 seeded block words", bn[0], 12);
    rd(5'd0, d);
    chk(d == 32'h4, "R5 ctrl readback seed", d, 4);

    // R4 bad range
    wr(5'd2, 10); wr(5'd3, 9);
    n0 = nreq;
    wr(5'd0, 1);
    repeat (10) @(negedge clk);
    rd(5'd1, d);
    chk(d[3] == 1 && d[0] == 0, "R4 range error idle", d, 32'h8);
    chk(nreq == n0, "R4 no reads", nreq - n0, 0);

    // Guard mode
    do_reset();
    rd(5'd1, d);
    chk(d == 0, "R9 full reset clears flags", d, 0);
    e = model_dig(30, 40, 0);
    for (int k = 0; k < 8; k++) wr(5'(8 + k), e[32*k +: 32]);
    wr(5'd2, 30); wr(5'd3, 40); wr(5'd4, 60);
    exp_addr = 30; win_lo = 30;
    wr(5'd0, 32'h2);
    // R6 locked writes during guard
    wr(5'd2, 0); wr(5'd4, 5); wr(5'd8, 32'h0);
    rd(5'd2, d);  chk(d == 30, "R6 start locked", d, 30);
    rd(5'd4, d);  chk(d == 60, "R6 period locked", d, 60);
    rd(5'd8, d);  chk(d == e[31:0], "R6 reference locked", d, e[31:0]);
    wr(5'd0, 32'h0);
    rd(5'd0, d);  chk(d[1] == 1, "R5 guard sticky", d, 2);
    gap_lo = 60;
    while (gap_seen < 2) begin
      @(negedge clk);
      if (exp_addr == 41) exp_addr = 30;
    end
    chk(gap_seen >= 2, "R7 repeated scans", gap_seen, 2);

    // R8 breach: corrupt memory, reset pulse follows
    mem[35] = mem[35] ^ 32'h1;
    allow_rst = 1;
    while (!rst_req) begin
      @(negedge clk);
      if (exp_addr == 41) exp_addr = 30;
    end
    while (rst_req) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(5'd1, d);
    chk(d[2] == 1, "R9 breach survives soft reset", d, 4);
    rd(5'd0, d);
    chk(d[1] == 0, "R9 guard cleared by soft reset", d, 0);
    n0 = nreq;
    repeat (200) @(negedge clk);
    chk(nreq == n0, "R9 scanning stopped", nreq - n0, 0);
    allow_rst = 0;
    do_reset();
    rd(5'd1, d);
    chk(d == 0, "R1 full reset clears breach", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule